// File: doc/BRIEF.md
# Two-Bit-Per-Stage Dual-Rail Ripple Adder With One-Hot Operand Groups

This block adds two dual-rail operands plus a dual-rail carry-in and returns a dual-rail sum and carry-out. Internally it is a chain of stages, and each stage adds two bits. Each pair of operand bits is re-coded into a one-hot group of four wires before it enters the stage. The carries between stages stay dual-rail. Each stage produces its two sum bits as a one-hot group of four, which is then decoded back to dual-rail at the output. Inside the stage the one-hot wire order is the mirror of the order at the encoder and decoder: pair value v drives interface wire v, and that wire feeds internal wire 3 - v.

The block is a discrete-step model of a self-timed circuit, evaluated on a sampling clock with a single register layer. A stage's carry-out is built from redundant two-input AND terms over its operand groups. It therefore resolves as soon as the operands alone decide it, and it drops back to spacer as soon as the operands do. A stage's sum behaves like a completion element: it only becomes valid once both operand groups and its carry-in are valid, and it only returns to spacer once all of them are spacer. In any other combination it holds its previous value. Because every carry resets in parallel, the sums can return to spacer without waiting for a reset wave along the chain.

Top module: `pair_ripple_adder`

## Requirements
- R1: While reset is low and on the first edge after it, every output rail is 0 (spacer).
- R2: Each operand bit and each output bit is carried on a true rail and a false rail. A true rail of 1 means value 1, a false rail of 1 means value 0, and both rails 0 means spacer. When all inputs are valid, one clock edge later the sum equals (A + B + cin) mod 2^W and the carry-out equals bit W of A + B + cin.
- R3: No output bit ever has both of its rails high.
- R4: The sum of a stage that is spacer stays spacer while its carry-in or either of its operand pairs is not valid. An operand pair counts as invalid when either of its bits is spacer.
- R5: A stage's carry-out resolves from its operand pair values a and b alone, whatever its carry-in: 1 when a + b >= 4 and 0 when a + b <= 2. When a + b = 3 it follows the carry-in.
- R6: When either operand pair of a stage is not valid, that stage's carry-out is spacer on the next edge, even if its carry-in is valid.
- R7: A valid stage sum keeps its value while some, but not all, of its operand pairs and carry-in are spacer.
- R8: When every input is spacer, every output is spacer one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_t | input | 2*PAIRS | Operand A, true rails |
| a_f | input | 2*PAIRS | Operand A, false rails |
| b_t | input | 2*PAIRS | Operand B, true rails |
| b_f | input | 2*PAIRS | Operand B, false rails |
| ci_t | input | 1 | Carry-in, true rail |
| ci_f | input | 1 | Carry-in, false rail |
| s_t | output | 2*PAIRS | Sum, true rails |
| s_f | output | 2*PAIRS | Sum, false rails |
| co_t | output | 1 | Carry-out, true rail |
| co_f | output | 1 | Carry-out, false rail |

## Verification
The bench tests vectors where every pair sums to three, so the carry ripples through the whole chain; a design with a broken propagate term, or a wrong mirrored wire mapping, gives wrong sums or a wrong carry-out. It applies operands with the carry-in still spacer. A design that did not wait for completion would show sums early, and one that ignored the generate and kill terms would leave the upper carries spacer. It withdraws single operand bits or only the carry-in after a valid result. This exposes sums that drop to spacer too soon instead of holding, and a carry-out that fails to reset at once. Random vectors with random spacer masks, compared against an integer model, cover the remaining combinations.

// File: rtl/pair_ripple_adder.sv
module pair_ripple_adder #(
  parameter int PAIRS = 4,
  localparam int W = 2 * PAIRS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] a_f,
  input  logic [W-1:0] b_t,
  input  logic [W-1:0] b_f,
  input  logic         ci_t,
  input  logic         ci_f,
  output logic [W-1:0] s_t,
  output logic [W-1:0] s_f,
  output logic         co_t,
  output logic         co_f
);

  logic [PAIRS-1:0] gen_v, kill_v, prp_v;
  logic [PAIRS:0]   c_t, c_f;

  always_comb begin
    c_t[0] = ci_t;
    c_f[0] = ci_f;
    for (int p = 0; p < PAIRS; p++) begin
      c_t[p+1] = gen_v[p]  | (prp_v[p] & c_t[p]);
      c_f[p+1] = kill_v[p] | (prp_v[p] & c_f[p]);
    end
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_stage
    logic [3:0] ea, eb, ia, ib, nxt, sg;
    logic       gen, kill, prp, all_v, all_s;

    assign ea = {a_t[2*p+1] & a_t[2*p], a_t[2*p+1] & a_f[2*p],
                 a_f[2*p+1] & a_t[2*p], a_f[2*p+1] & a_f[2*p]};
    assign eb = {b_t[2*p+1] & b_t[2*p], b_t[2*p+1] & b_f[2*p],
                 b_f[2*p+1] & b_t[2*p], b_f[2*p+1] & b_f[2*p]};

    assign ia = {ea[0], ea[1], ea[2], ea[3]};
    assign ib = {eb[0], eb[1], eb[2], eb[3]};

    always_comb begin
      gen  = 1'b0;
      kill = 1'b0;
      prp  = 1'b0;
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          if (i + j >= 4)      gen  = gen  | (ia[3-i] & ib[3-j]);
          else if (i + j == 3) prp  = prp  | (ia[3-i] & ib[3-j]);
          else                 kill = kill | (ia[3-i] & ib[3-j]);
        end
      end
    end

    assign gen_v[p]  = gen;
    assign kill_v[p] = kill;
    assign prp_v[p]  = prp;

    always_comb begin
      nxt = '0;
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          nxt[3-((i+j)%4)]   = nxt[3-((i+j)%4)]   | (ia[3-i] & ib[3-j] & c_f[p]);
          nxt[3-((i+j+1)%4)] = nxt[3-((i+j+1)%4)] | (ia[3-i] & ib[3-j] & c_t[p]);
        end
      end
    end

    assign all_v = (|ia) & (|ib) & (c_t[p] | c_f[p]);
    assign all_s = ~((|ia) | (|ib) | c_t[p] | c_f[p]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sg <= '0;
      else if (all_v) sg <= nxt;
      else if (all_s) sg <= '0;
    end

    assign s_t[2*p+1] = sg[0] | sg[1];
    assign s_t[2*p]   = sg[0] | sg[2];
    assign s_f[2*p+1] = sg[2] | sg[3];
    assign s_f[2*p]   = sg[1] | sg[3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      co_t <= 1'b0;
      co_f <= 1'b0;
    end else begin
      co_t <= c_t[PAIRS];
      co_f <= c_f[PAIRS];
    end
  end

endmodule

// File: rtl/pair_ripple_adder_props.sv
module pair_ripple_adder_props #(
  parameter int PAIRS = 4,
  localparam int W = 2 * PAIRS
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_t,
  input logic [W-1:0] a_f,
  input logic [W-1:0] b_t,
  input logic [W-1:0] b_f,
  input logic         ci_t,
  input logic         ci_f,
  input logic [W-1:0] s_t,
  input logic [W-1:0] s_f,
  input logic         co_t,
  input logic         co_f
);

  assert_reset_spacer_R1: assert property (@(posedge clk)
    !rst_n |=> (s_t == '0 && s_f == '0 && !co_t && !co_f));

  assert_rails_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_t & s_f) == '0) && !(co_t && co_f));

  assert_wait_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ci_t && !ci_f && s_t[1:0] == 2'b00 && s_f[1:0] == 2'b00)
      |=> (s_t[1:0] == 2'b00 && s_f[1:0] == 2'b00));

  assert_top_generate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_t[W-1] && b_t[W-1] && (a_t[W-2] || a_f[W-2]) && (b_t[W-2] || b_f[W-2]))
      |=> co_t);

  assert_top_kill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (a_f[W-1] && b_f[W-1] && (a_t[W-2] || a_f[W-2]) && (b_t[W-2] || b_f[W-2]))
      |=> co_f);

  assert_eager_carry_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_t[W-1] && !a_f[W-1]) |=> (!co_t && !co_f));

  assert_spacer_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_t == '0 && a_f == '0 && b_t == '0 && b_f == '0 && !ci_t && !ci_f)
      |=> (s_t == '0 && s_f == '0 && !co_t && !co_f));

endmodule

bind pair_ripple_adder pair_ripple_adder_props #(.PAIRS(PAIRS)) u_props (
  .clk(clk), .rst_n(rst_n), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
  .ci_t(ci_t), .ci_f(ci_f), .s_t(s_t), .s_f(s_f), .co_t(co_t), .co_f(co_f)
);

// File: tb/tb_pair_ripple_adder.sv
module tb_pair_ripple_adder;
  localparam int PAIRS = 4;
  localparam int W = 2 * PAIRS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
  logic ci_t = 1'b0, ci_f = 1'b0;
  logic [W-1:0] s_t, s_f;
  logic co_t, co_f;

  always #10 clk = ~clk;

  pair_ripple_adder #(.PAIRS(PAIRS)) dut (
    .clk(clk), .rst_n(rst_n), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
    .ci_t(ci_t), .ci_f(ci_f), .s_t(s_t), .s_f(s_f), .co_t(co_t), .co_f(co_f)
  );

  typedef struct packed {
    logic [W-1:0] st;
    logic [W-1:0] sf;
    logic         ct;
    logic         cf;
  } exp_t;

  exp_t  q[$];
  string rq[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  logic [1:0] ev [PAIRS];
  logic       eok[PAIRS];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] av, input logic [W-1:0] am,
                       input logic [W-1:0] bv, input logic [W-1:0] bm,
                       input logic cv, input logic cm, input string req);
    exp_t e;
    logic c_ok, c_v, aok, bok;
    int   va, vb;
    @(negedge clk);
    a_t = av & am;  a_f = ~av & am;
    b_t = bv & bm;  b_f = ~bv & bm;
    ci_t = cv & cm; ci_f = ~cv & cm;
    c_ok = cm; c_v = cv;
    e = '0;
    for (int p = 0; p < PAIRS; p++) begin
      aok = am[2*p] & am[2*p+1];
      bok = bm[2*p] & bm[2*p+1];
      va = int'(av[2*p+:2]);
      vb = int'(bv[2*p+:2]);
      if (aok && bok && c_ok) begin
        ev[p]  = 2'((va + vb + int'(c_v)) % 4);
        eok[p] = 1'b1;
      end else if (!aok && !bok && !c_ok) begin
        eok[p] = 1'b0;
      end
      if (aok && bok) begin
        if (va + vb >= 4) begin c_ok = 1'b1; c_v = 1'b1; end
        else if (va + vb <= 2) begin c_ok = 1'b1; c_v = 1'b0; end
      end else begin
        c_ok = 1'b0;
      end
      if (eok[p]) begin
        e.st[2*p+:2] = ev[p];
        e.sf[2*p+:2] = ~ev[p];
      end
    end
    e.ct = c_ok & c_v;
    e.cf = c_ok & ~c_v;
    q.push_back(e);
    rq.push_back(req);
  endtask

  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t  e;
      string r;
      e = q.pop_front();
      r = rq.pop_front();
      check({s_t, s_f, co_t, co_f} == e, r,
            32'({s_t, s_f, co_t, co_f}), 32'(e));
      check(((s_t & s_f) == '0) && !(co_t && co_f), "R3",
            32'({s_t & s_f, co_t & co_f}), 32'h0);
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual hung, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    logic [W-1:0] ones;
    ones = '1;
    for (int p = 0; p < PAIRS; p++) begin ev[p] = 2'b00; eok[p] = 1'b0; end
    repeat (3) @(negedge clk);
    check(s_t == '0 && s_f == '0 && !co_t && !co_f, "R1",
          32'({s_t, s_f, co_t, co_f}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(s_t == '0 && s_f == '0 && !co_t && !co_f, "R1",
          32'({s_t, s_f, co_t, co_f}), 32'h0);

    // R2 plain additions, R8 spacer between them
    drive(8'h5A, ones, 8'h33, ones, 1'b1, 1'b1, "R2");
    drive('0, '0, '0, '0, 1'b0, 1'b0, "R8");
    drive(8'hFF, ones, 8'h01, ones, 1'b0, 1'b1, "R2");
    drive('0, '0, '0, '0, 1'b0, 1'b0, "R8");
    // R4 full propagate chain with carry-in spacer, then carry-in arrives
    drive(8'h00, ones, 8'hFF, ones, 1'b0, 1'b0, "R4");
    drive(8'h00, ones, 8'hFF, ones, 1'b1, 1'b1, "R2");
    drive('0, '0, '0, '0, 1'b0, 1'b0, "R8");
    // R5 stage 0 generates, carry resolves without carry-in
    drive(8'h03, ones, 8'hFD, ones, 1'b0, 1'b0, "R5");
    drive('0, '0, '0, '0, 1'b0, 1'b0, "R8");
    drive(8'h00, ones, 8'h01, ones, 1'b0, 1'b0, "R5");
    drive('0, '0, '0, '0, 1'b0, 1'b0, "R8");
    // R6 and R7: withdraw one operand bit, then only the carry-in
    drive(8'h9C, ones, 8'h47, ones, 1'b0, 1'b1, "R2");
    drive(8'h9C, 8'h7F, 8'h47, ones, 1'b0, 1'b1, "R6");
    drive(8'h9C, ones, 8'h47, ones, 1'b0, 1'b0, "R7");
    drive(8'h9C, 8'hF0, 8'h47, 8'h0F, 1'b0, 1'b0, "R7");
    drive('0, '0, '0, '0, 1'b0, 1'b0, "R8");

    seed = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] av, bv, am, bm;
      logic cv, cm;
      seed = seed * 32'd1664525 + 32'd1013904223; av = seed[31:24];
      seed = seed * 32'd1664525 + 32'd1013904223; bv = seed[31:24];
      seed = seed * 32'd1664525 + 32'd1013904223;
      cv = seed[20];
      if (seed[31:29] == 3'b000) begin
        am = seed[15:8]; bm = seed[7:0]; cm = seed[16];
        drive(av, am, bv, bm, cv, cm, "R7");
      end else begin
        drive(av, ones, bv, ones, cv, 1'b1, "R2");
        drive('0, '0, '0, '0, 1'b0, 1'b0, "R8");
      end
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule